// File: doc/BRIEF.md
# Counter Overflow Summary Register

This block presents one read-only status word that collects the overflow flags of the programmable event counters, numbered 3 to 31. Software reads it at CSR address 0xDA0 to learn which counters have wrapped. It does not have to visit each counter's event register. Each summary bit is passed through only when machine mode has enabled that counter for the lower privilege level, through the counter-enable mask.

The overflow flag of each counter comes from one of two places, chosen by the active register width:
- In the narrow (32-bit) mode it is bit 31 of the counter's upper event register, given on `ovf_half_i`.
- In the wide (64-bit) mode it is bit 63 of the full event register, given on `ovf_wide_i`.

A strap tells the block whether the overflow extension is implemented. The block only reports the flags; setting and clearing them belong to the counters.

An access is a one-cycle request. The block decodes its own address. It answers exactly one cycle later with a registered snapshot of the summary taken in the request cycle, or with an illegal-access indication.

Top module: `ovf_summary_csr`

## Requirements
- R1: A read request (`csr_req_i`=1, `csr_we_i`=0) at address 0xDA0 with the extension strap high is answered in the next cycle with `rsp_valid_o`=1 and `rsp_illegal_o`=0.
- R2: For each i from 3 to 31, response bit i is 1 exactly when counter i's selected overflow flag is 1 and `cnt_enable_i[i]` is 1.
- R3: With `wide_mode_i`=0 the flag of counter i is `ovf_half_i[i]`. With `wide_mode_i`=1 it is `ovf_wide_i[i]`. The unselected vector has no effect.
- R4: Response bits 0 to 2 always read 0, whatever the inputs.
- R5: Response bits above bit 31 always read 0.
- R6: Any request at 0xDA0 while `ext_present_i`=0 is answered in the next cycle with `rsp_valid_o`=1, `rsp_illegal_o`=1 and data 0.
- R7: A write request at 0xDA0 is answered with `rsp_valid_o`=1, `rsp_illegal_o`=1 and data 0. A following read with the same inputs returns the same value as before the write.
- R8: A request at any other address, or no request, gives `rsp_valid_o`=0, `rsp_illegal_o`=0 and data 0 in the next cycle.
- R9: Response data is the value of the inputs in the request cycle. Input changes after that cycle do not alter the response.
- R10: During and right after reset, `rsp_valid_o`, `rsp_illegal_o` and `rsp_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_present_i | input | 1 | Strap: overflow extension implemented |
| wide_mode_i | input | 1 | 1 = 64-bit register mode, 0 = 32-bit mode |
| ovf_wide_i | input | NUM_CTR (32) | Bit 63 of each counter's event register |
| ovf_half_i | input | NUM_CTR (32) | Bit 31 of each counter's upper event register |
| cnt_enable_i | input | NUM_CTR (32) | Counter-enable mask to the lower privilege level |
| csr_req_i | input | 1 | CSR access request, one cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR address |
| rsp_valid_o | output | 1 | Response for an access at this block's address |
| rsp_illegal_o | output | 1 | Access is an illegal instruction |
| rsp_data_o | output | DATA_W (64) | Read data snapshot |

## Verification
A wrong source selection or a missing enable gate in the per-bit selector shows up as a wrong data bit in the response. That response arrives one cycle after the read that exposes it, so the bench uses flag and mask patterns that separate the two flag vectors and every gated bit. A fault in the access decode shows up in that same response cycle, as a missing or spurious `rsp_valid_o` or `rsp_illegal_o`. A response register that follows its inputs instead of holding the request-cycle snapshot is caught by changing the inputs just before the response is sampled.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
   // address at which the summary word is decoded
   localparam logic [11:0] OVS_CSR_ADDR = 12'hDA0;
   localparam int unsigned OVS_ADDR_W   = 12;

   typedef struct packed {
      logic hit;      // request targets this register
      logic illegal;  // request must trap
   } ovs_access_t;
endpackage

// File: rtl/ovs_flag_select.sv
module ovs_flag_select #(
   parameter int unsigned NUM_CTR   = 32,
   parameter int unsigned FIRST_CTR = 3
) (
   input  logic               wide_mode,
   input  logic [NUM_CTR-1:0] flags_wide,
   input  logic [NUM_CTR-1:0] flags_half,
   input  logic [NUM_CTR-1:0] enable,
   output logic [NUM_CTR-1:0] summary
);
   if (FIRST_CTR >= NUM_CTR) begin : g_bad_range
      $error("ovs_flag_select: FIRST_CTR must be below NUM_CTR");
   end

   // fixed counters below FIRST_CTR carry no flag
   logic unused_fixed;
   assign unused_fixed = ^{flags_wide[FIRST_CTR-1:0], flags_half[FIRST_CTR-1:0],
                           enable[FIRST_CTR-1:0]};

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_bit
      if (i < FIRST_CTR) begin : g_fixed
         assign summary[i] = 1'b0;
      end else begin : g_prog
         logic src;
         assign src        = wide_mode ? flags_wide[i] : flags_half[i];
         assign summary[i] = src & enable[i];
      end
   end
endmodule

// File: rtl/ovs_access_decode.sv
module ovs_access_decode
   import ovs_pkg::*;
#(
   parameter logic [OVS_ADDR_W-1:0] CSR_ADDR = OVS_CSR_ADDR
) (
   input  logic                  req,
   input  logic                  we,
   input  logic [OVS_ADDR_W-1:0] addr,
   input  logic                  ext_present,
   output ovs_access_t           acc
);
   always_comb begin
      acc.hit     = req && (addr == CSR_ADDR);
      acc.illegal = acc.hit && (we || !ext_present);
   end
endmodule

// File: rtl/ovs_resp_reg.sv
module ovs_resp_reg
   import ovs_pkg::*;
#(
   parameter int unsigned NUM_CTR = 32,
   parameter int unsigned DATA_W  = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  ovs_access_t        acc,
   input  logic [NUM_CTR-1:0] summary,
   output logic               rsp_valid,
   output logic               rsp_illegal,
   output logic [DATA_W-1:0]  rsp_data
);
   logic [DATA_W-1:0] wide_sum;

   if (DATA_W < NUM_CTR) begin : g_bad_width
      $error("ovs_resp_reg: DATA_W must hold NUM_CTR bits");
   end else if (DATA_W == NUM_CTR) begin : g_exact
      assign wide_sum = summary;
   end else begin : g_pad
      assign wide_sum = {{(DATA_W-NUM_CTR){1'b0}}, summary};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_illegal <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rsp_valid   <= acc.hit;
         rsp_illegal <= acc.illegal;
         rsp_data    <= (acc.hit && !acc.illegal) ? wide_sum : '0;
      end
   end
endmodule

// File: rtl/ovf_summary_csr.sv
module ovf_summary_csr
   import ovs_pkg::*;
#(
   parameter int unsigned NUM_CTR   = 32,
   parameter int unsigned FIRST_CTR = 3,
   parameter int unsigned DATA_W    = 64,
   parameter logic [OVS_ADDR_W-1:0] CSR_ADDR = OVS_CSR_ADDR
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ext_present_i,
   input  logic                  wide_mode_i,
   input  logic [NUM_CTR-1:0]    ovf_wide_i,
   input  logic [NUM_CTR-1:0]    ovf_half_i,
   input  logic [NUM_CTR-1:0]    cnt_enable_i,
   input  logic                  csr_req_i,
   input  logic                  csr_we_i,
   input  logic [OVS_ADDR_W-1:0] csr_addr_i,
   output logic                  rsp_valid_o,
   output logic                  rsp_illegal_o,
   output logic [DATA_W-1:0]     rsp_data_o
);
   ovs_access_t        acc;
   logic [NUM_CTR-1:0] summary;

   ovs_access_decode #(.CSR_ADDR(CSR_ADDR)) u_dec (
      .req         (csr_req_i),
      .we          (csr_we_i),
      .addr        (csr_addr_i),
      .ext_present (ext_present_i),
      .acc         (acc)
   );

   ovs_flag_select #(.NUM_CTR(NUM_CTR), .FIRST_CTR(FIRST_CTR)) u_sel (
      .wide_mode  (wide_mode_i),
      .flags_wide (ovf_wide_i),
      .flags_half (ovf_half_i),
      .enable     (cnt_enable_i),
      .summary    (summary)
   );

   ovs_resp_reg #(.NUM_CTR(NUM_CTR), .DATA_W(DATA_W)) u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (acc),
      .summary     (summary),
      .rsp_valid   (rsp_valid_o),
      .rsp_illegal (rsp_illegal_o),
      .rsp_data    (rsp_data_o)
   );
endmodule

// File: rtl/ovf_summary_chk.sv
module ovf_summary_chk
   import ovs_pkg::*;
#(
   parameter int unsigned NUM_CTR   = 32,
   parameter int unsigned FIRST_CTR = 3,
   parameter int unsigned DATA_W    = 64,
   parameter logic [OVS_ADDR_W-1:0] CSR_ADDR = OVS_CSR_ADDR
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ext_present_i,
   input logic                  wide_mode_i,
   input logic [NUM_CTR-1:0]    ovf_wide_i,
   input logic [NUM_CTR-1:0]    ovf_half_i,
   input logic [NUM_CTR-1:0]    cnt_enable_i,
   input logic                  csr_req_i,
   input logic                  csr_we_i,
   input logic [OVS_ADDR_W-1:0] csr_addr_i,
   input logic                  rsp_valid_o,
   input logic                  rsp_illegal_o,
   input logic [DATA_W-1:0]     rsp_data_o
);
   logic req_hit;
   assign req_hit = csr_req_i && (csr_addr_i == CSR_ADDR);

   AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      req_hit && !csr_we_i && ext_present_i |=> rsp_valid_o && !rsp_illegal_o); // R1
   AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      req_hit |=> (rsp_data_o[NUM_CTR-1:0] & ~$past(cnt_enable_i)) == '0); // R2
   AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_data_o[FIRST_CTR-1:0] == '0); // R4
   AST_ABSENT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      req_hit && !ext_present_i |=> rsp_valid_o && rsp_illegal_o && rsp_data_o == '0); // R6
   AST_WRITE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      req_hit && csr_we_i |=> rsp_illegal_o && rsp_data_o == '0); // R7
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_hit |=> !rsp_valid_o && !rsp_illegal_o && rsp_data_o == '0); // R8
   AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal_o |-> rsp_valid_o); // R6
endmodule

bind ovf_summary_csr ovf_summary_chk #(
   .NUM_CTR(NUM_CTR), .FIRST_CTR(FIRST_CTR), .DATA_W(DATA_W), .CSR_ADDR(CSR_ADDR)
) u_chk (.*);

// File: tb/sim_ovf_summary_csr.sv
`timescale 1ns/1ps
module sim_ovf_summary_csr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_present_i = 1'b1;
   logic        wide_mode_i = 1'b0;
   logic [31:0] ovf_wide_i = '0;
   logic [31:0] ovf_half_i = '0;
   logic [31:0] cnt_enable_i = '0;
   logic        csr_req_i = 1'b0;
   logic        csr_we_i = 1'b0;
   logic [11:0] csr_addr_i = '0;
   logic        rsp_valid_o;
   logic        rsp_illegal_o;
   logic [63:0] rsp_data_o;

   int errs = 0;
   int checks = 0;

   always #2 clk = ~clk;

   ovf_summary_csr u0 (.*);

   typedef struct packed {
      logic        wide;
      logic        ext;
      logic        we;
      logic [31:0] half;
      logic [31:0] wflag;
      logic [31:0] en;
      logic        exp_ill;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFF8},
      '{1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},
      '{1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'hAAAA_AAAA, 32'hFFFF_0000, 1'b0, 32'hAAAA_0000},
      '{1'b0, 1'b1, 1'b0, 32'h0000_000F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h0000_0008},
      '{1'b0, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_0000, 32'h0F0F_0F0F, 1'b0, 32'h0204_0608},
      '{1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'h8000_0007, 32'h8000_0007, 1'b0, 32'h8000_0000},
      '{1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
      '{1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
      '{1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 32'h0000_0000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // issue one access at a negedge; the response is sampled at the next negedge
   task automatic access(input logic [11:0] addr, input logic we);
      @(negedge clk);
      csr_addr_i = addr;
      csr_we_i   = we;
      csr_req_i  = 1'b1;
      @(negedge clk);
      csr_req_i  = 1'b0;
      csr_we_i   = 1'b0;
   endtask

   initial begin
      #400000;
      errs++;
      $display("FAIL watchdog act=running exp=done");
      finish_run();
   end

   initial begin
      // R10: reset state
      #1;
      chk("R10 valid in reset", {63'd0, rsp_valid_o}, 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 data after reset", rsp_data_o, 64'd0);
      chk("R10 illegal after reset", {63'd0, rsp_illegal_o}, 64'd0);

      // R1 R2 R3 R4 R5 R6 R7: table walk
      for (int k = 0; k < NV; k++) begin
         wide_mode_i   = TBL[k].wide;
         ext_present_i = TBL[k].ext;
         ovf_half_i    = TBL[k].half;
         ovf_wide_i    = TBL[k].wflag;
         cnt_enable_i  = TBL[k].en;
         access(12'hDA0, TBL[k].we);
         chk($sformatf("R1 valid vec%0d", k), {63'd0, rsp_valid_o}, 64'd1);
         chk($sformatf("R6_R7 illegal vec%0d", k), {63'd0, rsp_illegal_o},
             {63'd0, TBL[k].exp_ill});
         chk($sformatf("R2_R3_R4_R5 data vec%0d", k), rsp_data_o, {32'd0, TBL[k].exp});
      end

      // R8: other address and idle give nothing
      ext_present_i = 1'b1; wide_mode_i = 1'b0;
      ovf_half_i = 32'hFFFF_FFF8; cnt_enable_i = 32'hFFFF_FFFF;
      access(12'hDA1, 1'b0);
      chk("R8 other addr valid", {63'd0, rsp_valid_o}, 64'd0);
      chk("R8 other addr data", rsp_data_o, 64'd0);
      access(12'h5A0, 1'b1);
      chk("R8 other addr write illegal", {63'd0, rsp_illegal_o}, 64'd0);

      // R7: a write leaves the summary unchanged
      access(12'hDA0, 1'b0);
      chk("R7 before write", rsp_data_o, 64'h0000_0000_FFFF_FFF8);
      access(12'hDA0, 1'b1);
      chk("R7 write trapped", {63'd0, rsp_illegal_o}, 64'd1);
      access(12'hDA0, 1'b0);
      chk("R7 after write", rsp_data_o, 64'h0000_0000_FFFF_FFF8);

      // R9: snapshot holds against later input changes
      ovf_half_i = 32'h0000_0100;
      @(negedge clk);
      csr_addr_i = 12'hDA0; csr_req_i = 1'b1;
      @(negedge clk);
      csr_req_i  = 1'b0;
      ovf_half_i = 32'hF000_0000;
      cnt_enable_i = 32'h0;
      #1;
      chk("R9 snapshot", rsp_data_o, 64'h0000_0000_0000_0100);
      @(negedge clk);
      chk("R9 single response", {63'd0, rsp_valid_o}, 64'd0);

      // R10: reset mid-stream clears a pending response
      @(negedge clk);
      csr_req_i = 1'b1; cnt_enable_i = 32'hFFFF_FFFF;
      @(negedge clk);
      csr_req_i = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R10 async clear", rsp_data_o, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule